// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port with Open-Drain Option

This block controls six general-purpose pins from a small register bus. Software sets a direction, an output value and an open-drain choice for each pin. It reads back a pin-state view that shows, for each bit, the value being driven when the pin is an output and the synchronized level on the pin when it is an input. For each pin the block produces an output value and a tri-state enable for the pad. An open-drain pin only ever pulls low: when its output value is 1, the pad is released.

A serial peripheral can take any pin over through a per-pin ownership input. An owned pin takes its value and enable from that peripheral, and its open-drain setting still applies. When ownership is dropped, the pin returns at once to whatever the port registers say.

Power-on reset and hardware standby clear all three registers. Manual reset and software standby keep their contents and block bus writes while they are asserted. All control inputs are active high and sampled on the clock.

Top module: `gpio6_port`

## Requirements
- R1: Register addresses are 0 = direction, 1 = output data, 2 = open-drain control, 3 = pin state. A bus write (bus_sel=1, bus_wr=1) to address 0, 1 or 2 is stored on the clock edge. After that edge, reads of the same address return the stored value in bits 5:0. Reads are combinational.
- R2: While por or hw_stby is high at a clock edge, direction, data and open-drain all become 0 at that edge. Bus writes in that cycle are ignored.
- R3: While man_rst or sw_stby is high, the three registers keep their contents and bus writes are ignored.
- R4: Bits 7:6 of every write are ignored, and bits 7:6 of every read return 0.
- R5: A read of address 3 returns, per bit, the data bit when the direction bit is 1 and the synchronized pin level when it is 0. Writes to address 3 change no register.
- R6: For a pin that is not owned, direction 0 gives pin_oe=0. Direction 1 with open-drain 0 gives pin_oe=1. In both cases pin_out equals the data bit.
- R7: For a pin with open-drain 1 and a driven value of 1, pin_oe=0. With a driven value of 0, pin_oe follows the source enable.
- R8: When ser_own for a pin is 1, pin_out equals ser_out and the source enable is ser_oe, with the open-drain rule of R7 applied. When ser_own is 0, the registers drive the pin.
- R9: A change on pin_in is not visible in the pin-state read after one clock edge. It is visible after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, clears state |
| man_rst | input | 1 | Manual reset, retains state and blocks writes |
| hw_stby | input | 1 | Hardware standby, clears state |
| sw_stby | input | 1 | Software standby, retains state and blocks writes |
| bus_sel | input | 1 | Bus select |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 6 | Live pin levels |
| pin_out | output | 6 | Output value per pin |
| pin_oe | output | 6 | Tri-state enable per pin |
| ser_own | input | 6 | Serial peripheral owns pin |
| ser_out | input | 6 | Serial peripheral output value |
| ser_oe | input | 6 | Serial peripheral output enable |

## Verification
A register write takes effect on the edge that samples it. The read-back and both pad outputs are therefore checked at the falling edge one cycle after the write was driven. A pin_in change passes through two flops, so the bench samples the pin-state read at the falling edge after the first rising edge, where the old value must still show, and again after the second, where the new value is due. Serial ownership inputs act combinationally, so their checks sample a short delay after the stimulus within the same low phase.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned PINS  = 6;
    localparam int unsigned BUS_W = 8;
    localparam int unsigned ADR_W = 2;

    typedef enum logic [ADR_W-1:0] {
        RA_DIR = 2'd0,
        RA_DAT = 2'd1,
        RA_ODC = 2'd2,
        RA_PIN = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [PINS-1:0] dir;
        logic [PINS-1:0] dat;
        logic [PINS-1:0] odc;
    } port_regs_t;

    typedef struct packed {
        logic val;
        logic en;
    } drive_t;

    // open-drain suppresses the enable whenever the pin would go high
    function automatic drive_t resolve(input logic val, input logic en, input logic odc);
        drive_t r;
        r.val = val;
        r.en  = en & ~(odc & val);
        return r;
    endfunction

    function automatic logic [BUS_W-1:0] widen(input logic [PINS-1:0] v);
        return {{(BUS_W-PINS){1'b0}}, v};
    endfunction
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
(
    input  logic            clk,
    input  logic            por,
    input  logic            hw_stby,
    input  logic            hold,
    input  logic            wr_req,
    input  reg_addr_e       addr,
    input  logic [PINS-1:0] wdata,
    output port_regs_t      regs
);
    logic we;
    assign we = wr_req & ~hold;

    always_ff @(posedge clk) begin
        if (por || hw_stby) begin
            regs <= '0;
        end else if (we) begin
            case (addr)
                RA_DIR:  regs.dir <= wdata;
                RA_DAT:  regs.dat <= wdata;
                RA_ODC:  regs.odc <= wdata;
                default: ;
            endcase
        end
    end

    // R2: hardware standby empties the registers
    p_stby_clear_r2: assert property (@(posedge clk) disable iff (por)
        hw_stby |=> (regs == '0));

    // R3: manual reset / software standby keep contents
    p_hold_keep_r3: assert property (@(posedge clk) disable iff (por)
        (hold && !hw_stby) |=> $stable(regs));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         por,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (por) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_pkg::*;
(
    input  logic            clk,
    input  logic            por,
    input  port_regs_t      regs,
    input  logic [PINS-1:0] ser_own,
    input  logic [PINS-1:0] ser_out,
    input  logic [PINS-1:0] ser_oe,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe
);
    for (genvar g = 0; g < PINS; g++) begin : g_pin
        logic   src_val;
        logic   src_en;
        drive_t drv;

        assign src_val    = ser_own[g] ? ser_out[g] : regs.dat[g];
        assign src_en     = ser_own[g] ? ser_oe[g]  : regs.dir[g];
        assign drv        = resolve(src_val, src_en, regs.odc[g]);
        assign pin_out[g] = drv.val;
        assign pin_oe[g]  = drv.en;

        // R6: an input pin owned by the port never drives
        p_tristate_r6: assert property (@(posedge clk) disable iff (por)
            (!ser_own[g] && !regs.dir[g]) |-> !pin_oe[g]);

        // R7: open-drain pins never drive a high level
        p_od_low_only_r7: assert property (@(posedge clk) disable iff (por)
            regs.odc[g] |-> !(pin_oe[g] && pin_out[g]));

        // R8: an owned pin carries the serial value
        p_owner_val_r8: assert property (@(posedge clk) disable iff (por)
            ser_own[g] |-> (pin_out[g] == ser_out[g]));
    end
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
    import gpio_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por,
    input  logic             man_rst,
    input  logic             hw_stby,
    input  logic             sw_stby,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [PINS-1:0]  pin_in,
    output logic [PINS-1:0]  pin_out,
    output logic [PINS-1:0]  pin_oe,
    input  logic [PINS-1:0]  ser_own,
    input  logic [PINS-1:0]  ser_out,
    input  logic [PINS-1:0]  ser_oe
);
    port_regs_t      regs;
    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] pin_view;
    reg_addr_e       addr;
    logic            unused_rsvd;

    assign addr        = reg_addr_e'(bus_addr);
    assign unused_rsvd = ^bus_wdata[BUS_W-1:PINS];

    gpio_regfile u_regs (
        .clk     (clk),
        .por     (por),
        .hw_stby (hw_stby),
        .hold    (man_rst | sw_stby),
        .wr_req  (bus_sel & bus_wr),
        .addr    (addr),
        .wdata   (bus_wdata[PINS-1:0]),
        .regs    (regs)
    );

    gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .por (por),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_pad_ctl u_pad (
        .clk     (clk),
        .por     (por),
        .regs    (regs),
        .ser_own (ser_own),
        .ser_out (ser_out),
        .ser_oe  (ser_oe),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    assign pin_view = (regs.dir & regs.dat) | (~regs.dir & pin_sync);

    always_comb begin
        case (addr)
            RA_DIR:  bus_rdata = widen(regs.dir);
            RA_DAT:  bus_rdata = widen(regs.dat);
            RA_ODC:  bus_rdata = widen(regs.odc);
            default: bus_rdata = widen(pin_view);
        endcase
    end

    // R1: a written value is read back in the next cycle
    p_wr_readback_r1: assert property (@(posedge clk) disable iff (por || hw_stby)
        (bus_sel && bus_wr && !man_rst && !sw_stby && bus_addr == RA_DAT)
            |=> (regs.dat == $past(bus_wdata[PINS-1:0])));
endmodule

// File: tb/test_gpio6_port.sv
module test_gpio6_port;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       por, man_rst, hw_stby, sw_stby;
    logic       bus_sel, bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic [5:0] pin_in, pin_out, pin_oe, ser_own, ser_out, ser_oe;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    gpio6_port i_gpio6_port (
        .clk(clk), .por(por), .man_rst(man_rst), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .ser_own(ser_own), .ser_out(ser_out), .ser_oe(ser_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD*150000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] r;
        logic [5:0] eo, ee, ev;
        por = 1'b1; man_rst = 1'b0; hw_stby = 1'b0; sw_stby = 1'b0;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
        pin_in = 6'h00; ser_own = 6'h00; ser_out = 6'h00; ser_oe = 6'h00;
        repeat (3) @(negedge clk);
        por = 1'b0;

        // reset state (R2)
        for (int a = 0; a < 3; a++) begin
            rd(a[1:0], r); check("R2 reset value", r, 8'h00);
        end
        check("R6 reset tristate", {2'b00, pin_oe}, 8'h00);

        // R1 / R4 readback with reserved bits set
        wr(2'd0, 8'hC5); rd(2'd0, r); check("R1/R4 dir readback", r, 8'h05);
        wr(2'd1, 8'hFF); rd(2'd1, r); check("R1/R4 data readback", r, 8'h3F);
        wr(2'd2, 8'h9A); rd(2'd2, r); check("R1/R4 odc readback", r, 8'h1A);

        // R5 write to pin-state address changes nothing
        wr(2'd3, 8'h00);
        rd(2'd0, r); check("R5 dir after pin write", r, 8'h05);
        rd(2'd1, r); check("R5 data after pin write", r, 8'h3F);
        rd(2'd2, r); check("R5 odc after pin write", r, 8'h1A);

        // R3 manual reset and software standby retain, block writes
        man_rst = 1'b1;
        wr(2'd1, 8'h00); wr(2'd0, 8'h3F);
        rd(2'd1, r); check("R3 man_rst keeps data", r, 8'h3F);
        rd(2'd0, r); check("R3 man_rst keeps dir", r, 8'h05);
        man_rst = 1'b0; sw_stby = 1'b1;
        wr(2'd2, 8'h00);
        rd(2'd2, r); check("R3 sw_stby keeps odc", r, 8'h1A);
        sw_stby = 1'b0;

        // R2 hardware standby clears, write during it ignored
        hw_stby = 1'b1;
        wr(2'd1, 8'h2A);
        hw_stby = 1'b0;
        for (int a = 0; a < 3; a++) begin
            rd(a[1:0], r); check("R2 hw_stby clear", r, 8'h00);
        end
        wr(2'd0, 8'h11); por = 1'b1; @(negedge clk); por = 1'b0;
        rd(2'd0, r); check("R2 por clear", r, 8'h00);

        // R9 synchronizer latency, direction all inputs
        pin_in = 6'h00; repeat (3) @(negedge clk);
        pin_in = 6'h2A; bus_addr = 2'd3;
        @(negedge clk); rd(2'd3, r); check("R9 one edge old value", r, 8'h00);
        @(negedge clk); rd(2'd3, r); check("R9 two edges new value", r, 8'h2A);

        // R5/R6/R7 sweep over direction x data, derived open-drain pattern
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b++) begin
                logic [5:0] dv, bv, ov, pv;
                dv = a[5:0]; bv = b[5:0]; ov = dv ^ {bv[2:0], bv[5:3]}; pv = ~bv;
                pin_in = pv;
                wr(2'd0, {2'b11, dv}); wr(2'd1, {2'b10, bv}); wr(2'd2, {2'b01, ov});
                ee = dv & ~(ov & bv);
                check("R6/R7 pin_oe", {2'b00, pin_oe}, {2'b00, ee});
                check("R6 pin_out", {2'b00, pin_out}, {2'b00, bv});
                rd(2'd3, r); check("R5 pin view", r, {2'b00, (dv & bv) | (~dv & pv)});
            end
        end

        // R8 serial ownership sweep
        wr(2'd0, 8'h0F); wr(2'd1, 8'h33); wr(2'd2, 8'h24);
        ser_out = 6'h2D; ser_oe = 6'h3A;
        for (int o = 0; o < 64; o++) begin
            ser_own = o[5:0];
            #1;
            ev = (ser_own & ser_out) | (~ser_own & 6'h33);
            eo = (ser_own & ser_oe)  | (~ser_own & 6'h0F);
            ee = eo & ~(6'h24 & ev);
            check("R8 pin_out owned", {2'b00, pin_out}, {2'b00, ev});
            check("R8/R7 pin_oe owned", {2'b00, pin_oe}, {2'b00, ee});
            @(negedge clk);
        end
        ser_own = 6'h00;

        summary();
    end
endmodule